// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits between the receive deserializer and the receive FIFO. Every character the receiver reports passes through and goes into the FIFO one cycle later, whatever its value. While it passes, the character is compared with a programmable match character. When the two agree, a sticky detect flag is raised. The flag stays set until the host reads the interrupt status, and that read is signalled to the block by a one-cycle clear pulse.

Detection is on only when the detect enable is high and all four software flow-control enable bits are zero. A matched character is never consumed and never acts as a flow-control token. It is stored like any other character and only marked.

For word lengths shorter than eight bits, the bits above the word are forced to zero. This applies both to the character sent to the FIFO and to both sides of the comparison. Bit 0 of the match register lines up with the least significant received bit.

Top module: `rx_match_flagger`

## Requirements
- R1: After reset, fifo_we is 0, fifo_data is 0 and hit_flag is 0.
- R2: Every cycle with rx_valid high produces fifo_we high on the next cycle, whether or not the character matches.
- R3: fifo_we is low on every cycle that does not follow a cycle with rx_valid high.
- R4: When a character is accepted with detect_en high, swfc_en equal to 4'b0000, and a masked character equal to the masked match_char, hit_flag is 1 on the next cycle.
- R5: With detect_en low, no character sets hit_flag.
- R6: With any bit of swfc_en set, no character sets hit_flag, even with detect_en high.
- R7: Once hit_flag is set, it stays set until a cycle with status_rd high. On the cycle after that read it is 0, unless R8 applies.
- R8: If a match is detected in the same cycle as status_rd, the set wins and hit_flag stays 1.
- R9: word_len selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. fifo_data carries the character with every bit at or above the word length cleared. The comparison ignores those bits in both rx_char and match_char, and bit 0 of each is the least significant received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| detect_en | input | 1 | Special character detect enable |
| swfc_en | input | 4 | Software flow-control enables; must all be 0 for detection |
| word_len | input | 2 | Word length code: 0=5, 1=6, 2=7, 3=8 bits |
| match_char | input | 8 | Character to match |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| status_rd | input | 1 | Interrupt status read; clears hit_flag |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Character written to the FIFO |
| hit_flag | output | 1 | Sticky special character detected flag |

## Verification
The assertions assume that word_len, detect_en and swfc_en hold steady while a character is in flight. In particular, word_len must not change between an accepted character and its FIFO write, because the mask check looks one cycle back. The stimulus changes configuration only on cycles with rx_valid low and a settled FIFO output. It also drives every input on the falling clock edge, so each value is stable across the sampling edge.

// File: rtl/rx_match_flagger.sv
module rx_match_flagger #(
  parameter int CHAR_W = 8,
  parameter int FC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect_en,
  input  logic [FC_W-1:0]   swfc_en,
  input  logic [1:0]        word_len,
  input  logic [CHAR_W-1:0] match_char,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              status_rd,
  output logic              fifo_we,
  output logic [CHAR_W-1:0] fifo_data,
  output logic              hit_flag
);
  localparam logic [1:0] LEN_TOP = 2'd3;

  logic [1:0]        drop_bits;
  logic [CHAR_W-1:0] len_mask;
  logic [CHAR_W-1:0] rx_masked;
  logic              armed;
  logic              hit_now;

  assign drop_bits = LEN_TOP - word_len;
  assign len_mask  = {CHAR_W{1'b1}} >> drop_bits;
  assign rx_masked = rx_char & len_mask;
  assign armed     = detect_en && (swfc_en == '0);
  assign hit_now   = rx_valid && armed && (rx_masked == (match_char & len_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_we   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_we <= rx_valid;
      if (rx_valid) fifo_data <= rx_masked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hit_flag <= 1'b0;
    else if (hit_now)   hit_flag <= 1'b1;
    else if (status_rd) hit_flag <= 1'b0;
  end
endmodule

// File: rtl/rx_match_flagger_chk.sv
module rx_match_flagger_chk #(
  parameter int CHAR_W = 8,
  parameter int FC_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              detect_en,
  input logic [FC_W-1:0]   swfc_en,
  input logic [1:0]        word_len,
  input logic              rx_valid,
  input logic              status_rd,
  input logic              fifo_we,
  input logic [CHAR_W-1:0] fifo_data,
  input logic              hit_flag
);
  // R2
  write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> fifo_we);

  // R3
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !fifo_we);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!detect_en && !hit_flag) |=> !hit_flag);

  // R6
  swfc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((swfc_en != '0) && !hit_flag) |=> !hit_flag);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && !status_rd) |=> hit_flag);

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $stable(word_len)) |=>
      ((fifo_data & ~({CHAR_W{1'b1}} >> (2'd3 - word_len))) == '0));
endmodule

bind rx_match_flagger rx_match_flagger_chk #(.CHAR_W(CHAR_W), .FC_W(FC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .detect_en(detect_en), .swfc_en(swfc_en),
  .word_len(word_len), .rx_valid(rx_valid), .status_rd(status_rd),
  .fifo_we(fifo_we), .fifo_data(fifo_data), .hit_flag(hit_flag)
);

// File: tb/rx_match_flagger_bench.sv
module rx_match_flagger_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       detect_en = 1'b0;
  logic [3:0] swfc_en = 4'h0;
  logic [1:0] word_len = 2'd3;
  logic [7:0] match_char = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic       status_rd = 1'b0;
  logic       fifo_we;
  logic [7:0] fifo_data;
  logic       hit_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_match_flagger u_rx_match_flagger (
    .clk(clk), .rst_n(rst_n), .detect_en(detect_en), .swfc_en(swfc_en),
    .word_len(word_len), .match_char(match_char), .rx_valid(rx_valid),
    .rx_char(rx_char), .status_rd(status_rd), .fifo_we(fifo_we),
    .fifo_data(fifo_data), .hit_flag(hit_flag)
  );

  // {detect_en, swfc_en[3:0], word_len[1:0], match_char, rx_char, expected hit}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 4'h0, 2'd3, 8'h13, 8'h13, 1'b1},   // R4 exact 8-bit match
    {1'b1, 4'h0, 2'd3, 8'h13, 8'h12, 1'b0},   // R4 LSB differs
    {1'b1, 4'h0, 2'd3, 8'h80, 8'h01, 1'b0},   // R9 bit order
    {1'b0, 4'h0, 2'd3, 8'h5A, 8'h5A, 1'b0},   // R5 disabled
    {1'b1, 4'h1, 2'd3, 8'h5A, 8'h5A, 1'b0},   // R6 bit 0 set
    {1'b1, 4'h8, 2'd3, 8'h5A, 8'h5A, 1'b0},   // R6 bit 3 set
    {1'b1, 4'h0, 2'd0, 8'h05, 8'hE5, 1'b1},   // R9 5-bit, upper ignored
    {1'b1, 4'h0, 2'd0, 8'hF5, 8'h15, 1'b1},   // R9 5-bit, match upper ignored
    {1'b1, 4'h0, 2'd1, 8'h3F, 8'h1F, 1'b0},   // R9 6-bit bit 5 counts
    {1'b1, 4'h0, 2'd2, 8'h7F, 8'hFF, 1'b1},   // R9 7-bit
    {1'b1, 4'h0, 2'd2, 8'h40, 8'h00, 1'b0},   // R9 7-bit bit 6 counts
    {1'b1, 4'h0, 2'd3, 8'hFF, 8'hFF, 1'b1}    // R4 all ones
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  task automatic send(input logic [7:0] c);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 fifo_we", {7'd0, fifo_we}, 8'd0);
    check("R1 fifo_data", fifo_data, 8'd0);
    check("R1 hit_flag", {7'd0, hit_flag}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 idle", {7'd0, fifo_we}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      detect_en = v[23]; swfc_en = v[22:19]; word_len = v[18:17]; match_char = v[16:9];
      @(negedge clk);
      send(v[8:1]);
      check("R2 fifo_we", {7'd0, fifo_we}, 8'd1);
      check("R9 fifo_data", fifo_data, v[8:1] & mask_of(v[18:17]));
      check("R4/R5/R6 hit", {7'd0, hit_flag}, {7'd0, v[0]});
      @(negedge clk);
      check("R3 one-shot", {7'd0, fifo_we}, 8'd0);
      check("R7 held", {7'd0, hit_flag}, {7'd0, v[0]});
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      check("R7 cleared", {7'd0, hit_flag}, 8'd0);
    end

    // R7: sticky across non-matching traffic
    detect_en = 1'b1; swfc_en = 4'h0; word_len = 2'd3; match_char = 8'hA5;
    @(negedge clk);
    send(8'hA5);
    send(8'h00);
    send(8'h11);
    check("R7 sticky", {7'd0, hit_flag}, 8'd1);
    check("R2 back-to-back", {7'd0, fifo_we}, 8'd1);
    check("R2 data", fifo_data, 8'h11);

    // R8: match and read in same cycle
    status_rd = 1'b1;
    send(8'hA5);
    status_rd = 1'b0;
    check("R8 set wins", {7'd0, hit_flag}, 8'd1);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    check("R7 clear after R8", {7'd0, hit_flag}, 8'd0);

    // R8 from clear state: read with match
    status_rd = 1'b1;
    send(8'hA5);
    status_rd = 1'b0;
    check("R8 set from clear", {7'd0, hit_flag}, 8'd1);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset hit", {7'd0, hit_flag}, 8'd0);
    check("R1 re-reset data", fifo_data, 8'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule